// File: doc/BRIEF.md
# PIN Attempt Limiter with Sliding Threshold

This block decides whether an unlock attempt may proceed and whether it succeeds. It keeps an attempt counter that only ever moves upward and a threshold that marks the end of the current attempt budget. Each attempt first advances the counter. Only then is the counter checked against the threshold. When the budget is spent, the block raises a wipe request and stops taking attempts. Otherwise it compares a presented 32-byte hash against the stored one. The compare visits every byte, so a match and a mismatch take the same number of cycles.

A successful compare pulses `unlock` and moves the threshold to the counter value plus the budget (50 by default). A failed compare pulses `deny` and leaves the threshold alone, so repeated failures use up the budget. A provisioning request loads the threshold from the current counter value plus the budget. Computing the hashes and keeping the threshold in nonvolatile storage are the job of the surrounding logic.

Top module: `pin_attempt_gate`

## Requirements
- R1: The attempt counter starts at 0 at power-up and has no reset or decrement path. It advances by exactly one for each accepted attempt, whether the hash matches or not, and it saturates at all ones. An attempt is accepted when `attempt_start` is high, the block is idle and not halted, and `prov_req` is low.
- R2: The check uses the counter value after the increment. If that value is greater than or equal to the threshold, `wipe` rises one cycle after `attempt_start` is sampled, and no `unlock` or `deny` follows.
- R3: Once `wipe` is high, it stays high until reset. While it is high, `attempt_start` and `prov_req` have no effect: no `unlock` or `deny` appears and the threshold does not change.
- R4: A compare takes the same time whether the hashes match or differ, and wherever they differ. The compare begins one cycle after the attempt is sampled and reads one byte per cycle. Its one-cycle result pulse is high in the 33rd cycle after the edge that sampled `attempt_start`, which is 32 cycles after the compare begins. No result appears earlier.
- R5: When all 32 bytes match, `unlock` pulses and `threshold` becomes the counter value plus 50, saturating at all ones. When any byte differs, `deny` pulses and `threshold` is unchanged. `threshold` is a 32-bit little-endian value: bits [7:0] hold the least significant byte.
- R6: When the block is idle, `prov_req` sets `threshold` to the current counter value plus 50 on the next edge. A `prov_req` raised while an attempt is in progress is ignored.
- R7: An active-low reset clears `wipe`, `unlock` and `deny`, sets `threshold` to 0, and returns the block to idle. The attempt counter keeps its value across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (asynchronous) |
| attempt_start | input | 1 | Request to begin an unlock attempt |
| pres_hash | input | 256 | Presented hash; byte i is bits [8i+7:8i] |
| stored_hash | input | 256 | Stored reference hash, same byte layout |
| prov_req | input | 1 | Load the threshold from the counter plus the budget |
| unlock | output | 1 | One-cycle pulse: the hashes matched |
| deny | output | 1 | One-cycle pulse: the hashes differed |
| wipe | output | 1 | Budget exhausted; held until reset |
| threshold | output | 32 | Current threshold, little-endian byte order |

## Verification
The assertions check the following on every cycle:
- the counter never moves backwards and steps by one on each accepted attempt;
- `unlock`, `deny` and `wipe` are never high together;
- `wipe` stays high once set and only rises when the counter has reached the threshold;
- the threshold changes only on a success or a provisioning request.

Only the bench scenarios can show the rest:
- the exact result cycle for matches and for mismatches at the first, the last and random bytes;
- that exactly 49 denials come before the wipe;
- that the block ignores inputs while halted;
- that the counter value survives reset, seen through a later provisioning request.

// File: rtl/pin_attempt_gate.sv
module pin_attempt_gate #(
  parameter int CNT_W      = 32,
  parameter int HASH_BYTES = 32,
  parameter int BUDGET     = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    attempt_start,
  input  logic [HASH_BYTES*8-1:0] pres_hash,
  input  logic [HASH_BYTES*8-1:0] stored_hash,
  input  logic                    prov_req,
  output logic                    unlock,
  output logic                    deny,
  output logic                    wipe,
  output logic [CNT_W-1:0]        threshold
);
  localparam int IDX_W = (HASH_BYTES > 1) ? $clog2(HASH_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HASH_BYTES - 1);
  localparam logic [CNT_W:0] BUDGET_X = (CNT_W+1)'(BUDGET);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_CMP, S_HALT} st_t;

  st_t              st_q;
  logic [CNT_W-1:0] ctr_q = '0;
  logic [CNT_W-1:0] thr_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       diff_q;
  logic             unlock_q, deny_q, wipe_q;

  logic             idle_w;
  logic             accept_w;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] thr_cand;
  logic [7:0]       diff_now;

  assign idle_w   = (st_q == S_IDLE);
  assign accept_w = rst_n && idle_w && attempt_start && !prov_req;
  assign sum_w    = {1'b0, ctr_q} + BUDGET_X;
  assign thr_cand = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];
  assign diff_now = diff_q | (pres_hash[idx_q*8 +: 8] ^ stored_hash[idx_q*8 +: 8]);

  always_ff @(posedge clk) begin
    if (accept_w && ctr_q != '1) ctr_q <= ctr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      thr_q    <= '0;
      idx_q    <= '0;
      diff_q   <= '0;
      unlock_q <= 1'b0;
      deny_q   <= 1'b0;
      wipe_q   <= 1'b0;
    end else begin
      unlock_q <= 1'b0;
      deny_q   <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (prov_req)           thr_q <= thr_cand;
          else if (attempt_start) st_q  <= S_CHECK;
        end
        S_CHECK: begin
          if (ctr_q >= thr_q) begin
            wipe_q <= 1'b1;
            st_q   <= S_HALT;
          end else begin
            idx_q  <= '0;
            diff_q <= '0;
            st_q   <= S_CMP;
          end
        end
        S_CMP: begin
          diff_q <= diff_now;
          if (idx_q == LAST_IDX) begin
            unlock_q <= (diff_now == 8'h00);
            deny_q   <= (diff_now != 8'h00);
            if (diff_now == 8'h00) thr_q <= thr_cand;
            st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= S_HALT;
      endcase
    end
  end

  assign unlock    = unlock_q;
  assign deny      = deny_q;
  assign wipe      = wipe_q;
  assign threshold = thr_q;
endmodule

// File: rtl/pin_attempt_gate_chk.sv
module pin_attempt_gate_chk #(
  parameter int CNT_W  = 32,
  parameter int BUDGET = 50
) (
  input logic             clk,
  input logic             rst_n,
  input logic             attempt_start,
  input logic             prov_req,
  input logic             unlock,
  input logic             deny,
  input logic             wipe,
  input logic [CNT_W-1:0] threshold,
  input logic [CNT_W-1:0] ctr,
  input logic             idle
);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && attempt_start && !prov_req && !wipe && ctr != '1) |=> (ctr == $past(ctr) + 1'b1));

  a_r1_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    ctr >= $past(ctr));

  a_r2_wipe_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wipe) |-> (ctr >= $past(threshold)));

  a_r3_wipe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> wipe);

  a_r3_no_result_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock, deny, wipe}));

  a_r5_thr_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && ctr < ('1 - CNT_W'(BUDGET))) |-> (threshold - ctr == CNT_W'(BUDGET)));

  a_r6_thr_changes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(threshold) |-> (unlock || $past(prov_req)));
endmodule

bind pin_attempt_gate pin_attempt_gate_chk #(.CNT_W(CNT_W), .BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst_n(rst_n), .attempt_start(attempt_start), .prov_req(prov_req),
  .unlock(unlock), .deny(deny), .wipe(wipe), .threshold(threshold),
  .ctr(ctr_q), .idle(idle_w)
);

// File: tb/sim_pin_attempt_gate.sv
module sim_pin_attempt_gate;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         attempt_start = 1'b0;
  logic [255:0] pres_hash = '0;
  logic [255:0] stored_hash = '0;
  logic         prov_req = 1'b0;
  logic         unlock, deny, wipe;
  logic [31:0]  threshold;

  int checks = 0;
  int errors = 0;
  logic [31:0] ctr_m = 0;
  logic [31:0] thr_m = 0;
  bit halted_m = 0;
  int denies_seen = 0;

  always #2 clk = ~clk;

  pin_attempt_gate u0 (.*);

  function automatic logic [31:0] add_budget(input logic [31:0] c);
    logic [32:0] s = {1'b0, c} + 33'd50;
    return s[32] ? 32'hFFFF_FFFF : s[31:0];
  endfunction

  function automatic logic [255:0] rand_hash();
    logic [255:0] h;
    for (int i = 0; i < 8; i++) h[i*32 +: 32] = $urandom;
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    halted_m = 0;
    thr_m = 0;
    #1;
    chk("R7 unlock after reset", {31'b0, unlock}, 0);
    chk("R7 deny after reset", {31'b0, deny}, 0);
    chk("R7 wipe after reset", {31'b0, wipe}, 0);
    chk("R7 threshold after reset", threshold, 0);
  endtask

  task automatic do_prov();
    @(negedge clk);
    prov_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    prov_req = 1'b0;
    if (!halted_m) thr_m = add_budget(ctr_m);
    chk(halted_m ? "R3 prov ignored when halted" : "R6 prov threshold", threshold, thr_m);
  endtask

  task automatic run_attempt(input logic [255:0] p, input logic [255:0] s, input bit prov_mid);
    bit early;
    bit match;
    @(negedge clk);
    pres_hash = p;
    stored_hash = s;
    attempt_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    attempt_start = 1'b0;
    if (halted_m) begin
      early = 0;
      for (int i = 0; i < 34; i++) begin
        @(posedge clk); #1;
        if (unlock || deny) early = 1;
      end
      chk("R3 no result while halted", {31'b0, early}, 0);
      chk("R3 wipe held", {31'b0, wipe}, 1);
      chk("R3 threshold held", threshold, thr_m);
      return;
    end
    if (ctr_m != 32'hFFFF_FFFF) ctr_m = ctr_m + 1;
    if (ctr_m >= thr_m) begin
      @(posedge clk); #1;
      chk("R2 wipe at limit", {31'b0, wipe}, 1);
      halted_m = 1;
      early = 0;
      for (int i = 0; i < 34; i++) begin
        @(posedge clk); #1;
        if (unlock || deny) early = 1;
      end
      chk("R2 no compare after wipe", {31'b0, early}, 0);
      return;
    end
    match = (p == s);
    early = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      if (unlock || deny || wipe) early = 1;
      prov_req = prov_mid && (i == 10);
    end
    prov_req = 1'b0;
    chk("R4 no early result", {31'b0, early}, 0);
    @(posedge clk); #1;
    chk("R4 R5 unlock pulse", {31'b0, unlock}, {31'b0, match});
    chk("R4 R5 deny pulse", {31'b0, deny}, {31'b0, !match});
    if (match) thr_m = add_budget(ctr_m);
    else denies_seen++;
    chk(prov_mid ? "R6 prov ignored mid attempt" : "R5 threshold", threshold, thr_m);
  endtask

  initial begin
    logic [255:0] a, b;
    void'($urandom(32'h5EED_0042));
    do_reset();
    do_prov();
    a = rand_hash();
    run_attempt(a, a, 0);
    b = a; b[7:0] = ~b[7:0];
    run_attempt(b, a, 0);
    b = a; b[255:248] = b[255:248] ^ 8'h01;
    run_attempt(b, a, 0);
    run_attempt(a, a, 1);
    for (int n = 0; n < 60; n++) begin
      int pos;
      a = rand_hash();
      b = a;
      if ($urandom % 10 < 3) begin
        pos = $urandom % 32;
        b[pos*8 +: 8] = b[pos*8 +: 8] ^ (8'($urandom % 255) + 8'd1);
      end
      run_attempt(b, a, 0);
    end
    a = rand_hash();
    run_attempt(a, a, 0);
    denies_seen = 0;
    b = ~a;
    while (!halted_m) run_attempt(b, a, 0);
    chk("R2 denies before wipe", denies_seen, 49);
    run_attempt(a, a, 0);
    do_prov();
    do_reset();
    do_prov();
    a = rand_hash();
    run_attempt(a, a, 0);
    chk("R1 counter preserved", threshold, add_budget(ctr_m));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule